// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between the retirement stage of a core that follows total store ordering and its data cache. Each retired store (word address, data, byte enables) is appended to a circular queue. The queue then offers its entries to the cache one at a time, oldest first. An entry leaves only when the cache accepts it. A store that would hit in the cache therefore still waits behind an older store that the cache is slow to take.

Loads look up the queue by word address every cycle. If the youngest queued store to that word has byte enables that cover every byte the load wants, the block returns a hit and that store's data. If the youngest match covers only some of the requested bytes, the block flags a partial hit, and the load must wait until that store has drained. A store is normally given its own word-sized entry. The single exception is a store to the same word as the store just before it, which is folded into that entry.

For a store barrier or an atomic read-modify-write, the core raises a drain request. While the request is high, new stores are refused. The done flag goes high once the queue has emptied. The capacity is a power of two from 2 to 64 entries, a limit set by the cost of the associative compare.

Top module: `store_buffer`

## Requirements
- R1: The cache write port always presents the oldest queued entry, and entries leave in the order they were pushed, one for each cycle in which `cacheValid` and `cacheReady` are both high.
- R2: `cacheValid` is high exactly when the queue holds at least one entry. While it is high and `cacheReady` is low, the presented address, data and mask do not change.
- R3: When the youngest queued entry whose address equals `ldAddr` has a mask that covers every set bit of `ldMask`, `ldHit` is 1, `ldPartial` is 0, and `ldData` carries that entry's bytes. Bit 8*b+7..8*b of the data belongs to mask bit b.
- R4: When the youngest matching entry lacks some byte requested in `ldMask`, `ldPartial` is 1 and `ldHit` is 0, even if an older entry holds the missing bytes.
- R5: When no queued entry matches `ldAddr`, both `ldHit` and `ldPartial` are 0.
- R6: An accepted push to the same word address as the youngest entry is merged into that entry, provided the queue holds at least two entries. The merge overwrites the bytes enabled in `pushMask` and ORs the masks, and it creates no new entry.
- R7: Any other accepted push creates a new entry, including a push whose address matches an older entry that is not the youngest.
- R8: `pushReady` is 0 whenever the queue holds DEPTH entries.
- R9: While `drainReq` is high, `pushReady` is 0. `drainDone` equals `drainReq` AND (queue empty).
- R10: After reset the queue is empty: `cacheValid` is 0, `pushReady` is 1 when `drainReq` is low, and no lookup hits.
- R11: A store pushed in a cycle becomes visible to lookups and to the cache port from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Retired store offered |
| pushReady | output | 1 | Store accepted this cycle if pushValid |
| pushAddr | input | ADDR_W | Word address of the store |
| pushData | input | DATA_W | Store data |
| pushMask | input | DATA_W/8 | Byte enables of the store |
| ldAddr | input | ADDR_W | Word address of the load lookup |
| ldMask | input | DATA_W/8 | Bytes the load needs |
| ldHit | output | 1 | Youngest match covers the load |
| ldPartial | output | 1 | Youngest match covers it only in part |
| ldData | output | DATA_W | Data of the youngest match |
| cacheValid | output | 1 | Oldest entry offered to the cache |
| cacheReady | input | 1 | Cache takes the offered entry |
| cacheAddr | output | ADDR_W | Word address of the oldest entry |
| cacheData | output | DATA_W | Data of the oldest entry |
| cacheMask | output | DATA_W/8 | Byte enables of the oldest entry |
| drainReq | input | 1 | Barrier or atomic operation waits for empty |
| drainDone | output | 1 | Queue empty while drain requested |

## Verification
The stability property on the cache port assumes that the cache only ever takes the presented entry through `cacheReady`. The drain properties assume that the core holds `drainReq` steady on its own schedule. Neither input is tied to any other input. The stimulus draws pushes, cache readiness and drain requests from a shift-register generator. Addresses are confined to four words so that repeated, adjacent and interleaved stores are frequent, and load masks are always non-zero. A separate sweep holds a fixed queue and walks every load address and mask combination in the small configuration.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  // Write strobes from the control half into the entry storage
  typedef struct packed {
    logic alloc;   // write a fresh entry at the write pointer
    logic merge;   // fold the push into the youngest entry
  } sbStrobe_t;
endpackage

// File: rtl/sb_ctrl.sv
`timescale 1ns/1ps
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             drainReq,
  input  logic             cacheReady,
  input  logic             tailMatch,
  output sbStrobe_t        strobe,
  output logic             pushReady,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [CNT_W-1:0] occ
);
  logic isFull, isEmpty, doPush, doPop, canMerge;

  assign isFull    = (occ == CNT_W'(DEPTH));
  assign isEmpty   = (occ == '0);
  assign pushReady = !isFull && !drainReq;
  assign doPush    = pushValid && pushReady;
  assign doPop     = !isEmpty && cacheReady;
  // the head entry is never merged into, so the cache sees stable data
  assign canMerge  = tailMatch && (occ >= CNT_W'(2));
  assign tailPtr   = wrPtr - PTR_W'(1);

  always_comb begin
    strobe       = '0;
    strobe.merge = doPush && canMerge;
    strobe.alloc = doPush && !canMerge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strobe.alloc) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)        rdPtr <= rdPtr + PTR_W'(1);
      occ <= occ + CNT_W'(strobe.alloc) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/sb_data.sv
`timescale 1ns/1ps
module sb_data
  import sb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  sbStrobe_t         strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [CNT_W-1:0]  occ,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic [NB-1:0]     pushMask,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [NB-1:0]     ldMask,
  output logic              tailMatch,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [NB-1:0]     headMask,
  output logic              ldHit,
  output logic              ldPartial,
  output logic [DATA_W-1:0] ldData
);
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [NB-1:0]     maskQ [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.alloc) begin
      addrQ[wrPtr] <= pushAddr;
      dataQ[wrPtr] <= pushData;
      maskQ[wrPtr] <= pushMask;
    end else if (strobe.merge) begin
      for (int b = 0; b < NB; b++)
        if (pushMask[b]) dataQ[tailPtr][8*b +: 8] <= pushData[8*b +: 8];
      maskQ[tailPtr] <= maskQ[tailPtr] | pushMask;
    end
  end

  assign tailMatch = (addrQ[tailPtr] == pushAddr);
  assign headAddr  = addrQ[rdPtr];
  assign headData  = dataQ[rdPtr];
  assign headMask  = maskQ[rdPtr];

  // associative search, oldest to youngest: the last match wins
  logic          found;
  logic [NB-1:0] foundMask;
  always_comb begin
    found     = 1'b0;
    foundMask = '0;
    ldData    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CNT_W'(k) < occ) && (addrQ[rdPtr + PTR_W'(k)] == ldAddr)) begin
        found     = 1'b1;
        foundMask = maskQ[rdPtr + PTR_W'(k)];
        ldData    = dataQ[rdPtr + PTR_W'(k)];
      end
    end
  end

  assign ldHit     = found && ((ldMask & ~foundMask) == '0);
  assign ldPartial = found && ((ldMask & ~foundMask) != '0);
endmodule

// File: rtl/store_buffer.sv
`timescale 1ns/1ps
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  output logic              pushReady,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic [NB-1:0]     pushMask,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [NB-1:0]     ldMask,
  output logic              ldHit,
  output logic              ldPartial,
  output logic [DATA_W-1:0] ldData,
  output logic              cacheValid,
  input  logic              cacheReady,
  output logic [ADDR_W-1:0] cacheAddr,
  output logic [DATA_W-1:0] cacheData,
  output logic [NB-1:0]     cacheMask,
  input  logic              drainReq,
  output logic              drainDone
);
  sbStrobe_t        strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr, tailPtr;
  logic [CNT_W-1:0] occ;
  logic             tailMatch;

  sb_ctrl #(.DEPTH(DEPTH)) ctrlI (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .drainReq(drainReq),
    .cacheReady(cacheReady), .tailMatch(tailMatch), .strobe(strobe),
    .pushReady(pushReady), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .tailPtr(tailPtr), .occ(occ)
  );

  sb_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dataI (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .tailPtr(tailPtr), .occ(occ), .pushAddr(pushAddr), .pushData(pushData),
    .pushMask(pushMask), .ldAddr(ldAddr), .ldMask(ldMask),
    .tailMatch(tailMatch), .headAddr(cacheAddr), .headData(cacheData),
    .headMask(cacheMask), .ldHit(ldHit), .ldPartial(ldPartial),
    .ldData(ldData)
  );

  assign cacheValid = (occ != '0);
  assign drainDone  = drainReq && (occ == '0);
endmodule

// File: rtl/store_buffer_chk.sv
`timescale 1ns/1ps
module store_buffer_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              pushReady,
  input logic              ldHit,
  input logic              ldPartial,
  input logic              cacheValid,
  input logic              cacheReady,
  input logic [ADDR_W-1:0] cacheAddr,
  input logic [DATA_W-1:0] cacheData,
  input logic [NB-1:0]     cacheMask,
  input logic              drainReq,
  input logic              drainDone,
  input logic [CNT_W-1:0]  occ
);
  // R8
  full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH)) |-> !pushReady);

  // R2
  head_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cacheValid && !cacheReady) |=> (cacheValid && $stable(cacheAddr) &&
                                     $stable(cacheData) && $stable(cacheMask)));

  // R9
  drain_blocks_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainReq |-> !pushReady);

  // R9
  done_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> (!cacheValid && drainReq));

  // R4
  hit_partial_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ldHit && ldPartial));

  // R1
  last_entry_leaves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cacheValid && cacheReady && occ == CNT_W'(1) && !(pushValid && pushReady))
      |=> !cacheValid);

  // R11
  occ_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0 && pushValid && pushReady) |=> (occ == CNT_W'(1)));
endmodule

bind store_buffer store_buffer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushReady(pushReady),
  .ldHit(ldHit), .ldPartial(ldPartial), .cacheValid(cacheValid),
  .cacheReady(cacheReady), .cacheAddr(cacheAddr), .cacheData(cacheData),
  .cacheMask(cacheMask), .drainReq(drainReq), .drainDone(drainDone), .occ(occ)
);

// File: tb/store_buffer_test.sv
`timescale 1ns/1ps
module store_buffer_test;
  localparam int DEPTH = 4;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int NB    = DW / 8;

  logic clk = 1'b0;
  logic rstN;
  logic pushValid, pushReady, ldHit, ldPartial, cacheValid, cacheReady;
  logic drainReq, drainDone;
  logic [AW-1:0] pushAddr, ldAddr, cacheAddr;
  logic [DW-1:0] pushData, ldData, cacheData;
  logic [NB-1:0] pushMask, ldMask, cacheMask;

  always #4 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushReady(pushReady),
    .pushAddr(pushAddr), .pushData(pushData), .pushMask(pushMask),
    .ldAddr(ldAddr), .ldMask(ldMask), .ldHit(ldHit), .ldPartial(ldPartial),
    .ldData(ldData), .cacheValid(cacheValid), .cacheReady(cacheReady),
    .cacheAddr(cacheAddr), .cacheData(cacheData), .cacheMask(cacheMask),
    .drainReq(drainReq), .drainDone(drainDone)
  );

  int nRun = 0, nFail = 0;
  bit finished = 0;

  // reference queue, index 0 = oldest
  logic [AW-1:0] mA [DEPTH];
  logic [DW-1:0] mD [DEPTH];
  logic [NB-1:0] mM [DEPTH];
  int mCnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] byteMask(input logic [NB-1:0] m);
    logic [DW-1:0] r = '0;
    for (int b = 0; b < NB; b++) if (m[b]) r[8*b +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic step(input logic pv, input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                      input logic [NB-1:0] pm, input logic [AW-1:0] la,
                      input logic [NB-1:0] lm, input logic cr, input logic dr);
    bit expReady, expHit, expPart, doPop, doPush;
    int fnd;
    @(negedge clk);
    pushValid = pv; pushAddr = pa; pushData = pd; pushMask = pm;
    ldAddr = la; ldMask = lm; cacheReady = cr; drainReq = dr;
    #2;
    expReady = (mCnt < DEPTH) && !dr;
    chk(pushReady == expReady, "R8/R9 pushReady", 64'(pushReady), 64'(expReady));
    chk(cacheValid == (mCnt > 0), "R2 cacheValid", 64'(cacheValid), 64'(mCnt > 0));
    if (mCnt > 0)
      chk({cacheAddr, cacheData, cacheMask} == {mA[0], mD[0], mM[0]}, "R1 head entry",
          64'({cacheAddr, cacheMask}), 64'({mA[0], mM[0]}));
    chk(drainDone == (dr && mCnt == 0), "R9 drainDone", 64'(drainDone), 64'(dr && mCnt == 0));
    fnd = -1;
    for (int k = 0; k < mCnt; k++) if (mA[k] == la) fnd = k;
    expHit  = (fnd >= 0) && ((lm & ~mM[fnd]) == '0);
    expPart = (fnd >= 0) && !expHit;
    chk(ldHit == expHit, "R3/R5 ldHit", 64'(ldHit), 64'(expHit));
    chk(ldPartial == expPart, "R4/R5 ldPartial", 64'(ldPartial), 64'(expPart));
    if (expHit)
      chk((ldData & byteMask(lm)) == (mD[fnd] & byteMask(lm)), "R3 ldData",
          64'(ldData & byteMask(lm)), 64'(mD[fnd] & byteMask(lm)));
    @(posedge clk);
    // model update for the edge just taken (R6, R7, R11)
    doPop  = (mCnt > 0) && cr;
    doPush = pv && expReady;
    if (doPush && mCnt >= 2 && mA[mCnt-1] == pa) begin
      for (int b = 0; b < NB; b++) if (pm[b]) mD[mCnt-1][8*b +: 8] = pd[8*b +: 8];
      mM[mCnt-1] = mM[mCnt-1] | pm;
      doPush = 0;
    end
    if (doPop) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        mA[k] = mA[k+1]; mD[k] = mD[k+1]; mM[k] = mM[k+1];
      end
      mCnt--;
    end
    if (doPush) begin
      mA[mCnt] = pa; mD[mCnt] = pd; mM[mCnt] = pm; mCnt++;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] nextRs(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    rstN = 0; pushValid = 0; pushAddr = '0; pushData = '0; pushMask = '0;
    ldAddr = '0; ldMask = 4'hF; cacheReady = 0; drainReq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #2;
    // R10 reset state
    chk(!cacheValid, "R10 cacheValid", 64'(cacheValid), 0);
    chk(pushReady, "R10 pushReady", 64'(pushReady), 1);
    chk(!ldHit && !ldPartial, "R10 lookup", 64'({ldHit, ldPartial}), 0);

    // R7: repeated address that is not adjacent gets its own entry; R11 same-cycle lookup misses
    step(1, 6'd1, 32'h1111_1111, 4'hF, 6'd1, 4'hF, 0, 0);
    step(1, 6'd2, 32'h2222_2222, 4'hF, 6'd1, 4'hF, 0, 0);
    step(1, 6'd1, 32'hAAAA_AAAA, 4'h3, 6'd1, 4'h3, 0, 0);
    // R3 youngest forwarded; R4 partial although an older entry covers
    step(0, 6'd0, 32'h0, 4'h0, 6'd1, 4'h3, 0, 0);
    step(0, 6'd0, 32'h0, 4'h0, 6'd1, 4'hC, 0, 0);
    // R6 merge into youngest, then full hit
    step(1, 6'd1, 32'hBBBB_BBBB, 4'hC, 6'd1, 4'hF, 0, 0);
    step(0, 6'd0, 32'h0, 4'h0, 6'd1, 4'hF, 0, 0);
    chk(ldHit && ldData == 32'hBBBB_AAAA, "R6 merged data", 64'(ldData), 64'h BBBB_AAAA);
    // R8 fill to full, extra push refused
    step(1, 6'd5, 32'h5555_5555, 4'hF, 6'd5, 4'hF, 0, 0);
    step(1, 6'd6, 32'h6666_6666, 4'hF, 6'd6, 4'hF, 0, 0);
    step(1, 6'd7, 32'h7777_7777, 4'hF, 6'd7, 4'hF, 0, 0);
    // R5 miss
    step(0, 6'd0, 32'h0, 4'h0, 6'd9, 4'hF, 0, 0);
    // exhaustive lookup sweep over a fixed queue (R3, R4, R5)
    for (int a = 0; a < 8; a++)
      for (int m = 1; m < 16; m++)
        step(0, 6'd0, 32'h0, 4'h0, 6'(a), 4'(m), 0, 0);
    // R9 drain with a stalling cache, then R1 order
    for (int i = 0; i < 12; i++)
      step(1, 6'd3, 32'h3333_3333, 4'hF, 6'd1, 4'hF, 1'(i % 3 == 2), 1);
    step(0, 6'd0, 32'h0, 4'h0, 6'd1, 4'hF, 0, 0);

    // pseudo-random sweep over a four-word address window
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2;
      rs = nextRs(rs); r1 = rs;
      rs = nextRs(rs); r2 = rs;
      step(r1[0] | r1[1], 6'(r1[3:2]), r2, (r1[7:4] == 0) ? 4'h1 : r1[7:4],
           6'(r1[9:8]), (r1[13:10] == 0) ? 4'hF : r1[13:10],
           r1[14] & (r1[15] | r1[16]), (r1[20:17] == 0));
    end
    finish();
  end
endmodule